// File: doc/BRIEF.md
# Programmable Supervisory Watchdog Timer

This block watches for a processor that has stopped running its normal code. Software programs a control byte that sets a timeout as a 5-bit multiplier times one of four resolutions. It then has to restart the timer before the timeout runs out. It can do that by toggling a kick pin (either edge counts) or by writing the control byte again. If the timeout runs out, the block sets a watchdog flag. A steering bit in the control byte then chooses the response. With the steering bit clear, a level interrupt is raised. With it set, an active-low reset pulse of fixed width is driven, and at the end of that pulse the four enable bits of a neighbouring enable register are cleared.

The timer counts a single-cycle 16 Hz timebase tick. The resolutions are 1, 4, 16 and 64 ticks. Because the count restarts from a full load on every kick, the timeout is accurate to within one resolution step. Registers are reached through a small synchronous port. Writes and the clear-on-read of the flag act at the clock edge. Read data is driven combinationally from the address.

The controller has four states. `ST_IDLE` means the multiplier is zero. `ST_COUNT` means the timer is counting down. `ST_IRQ` means the timer expired with the steering bit clear. `ST_PULSE` means the timer expired with the steering bit set and the reset pulse is running. The transitions are:
- arm: `ST_IDLE`→`ST_COUNT`, on a restart with a nonzero multiplier.
- disarm: any of `ST_COUNT`/`ST_IRQ`→`ST_IDLE`, on a restart with a zero multiplier.
- reload: `ST_COUNT`→`ST_COUNT`, on a restart.
- expire-irq: `ST_COUNT`→`ST_IRQ`.
- expire-pulse: `ST_COUNT`→`ST_PULSE`.
- resume: `ST_IRQ`→`ST_COUNT`, on a restart or a flag read.
- pulse-end: `ST_PULSE`→`ST_COUNT`, or to `ST_IDLE` when the multiplier is zero.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset, `irq_o` is 0, `wdt_rst_n` is 1, and the control byte, flag register and enable register all read 0. The timer is idle.
- R2: Register map, selected by `addr`:
  - Address 0 is the read/write control byte: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution.
  - Address 1 is the flag register: bit 7 is the watchdog flag, other bits read 0.
  - Address 2 is the enable register: bits 3:0 are read/write, bits 7:4 read 0.
  - Address 3 reads 0.
  - `rdata` shows the addressed register in the same cycle.
- R3: The timeout is multiplier × resolution ticks, where resolution 00/01/10/11 gives 1/4/16/64 ticks. Expiry happens at the edge that samples the timeout-th tick after the last restart, and the flag reads 1 from the next cycle.
- R4: While the multiplier is 0 the timer is idle. No flag, interrupt or reset pulse is produced.
- R5: On expiry with steering 0, `irq_o` goes to 1 the cycle after the expiring edge and counting stops. `irq_o` stays 1 until a restart, or until a read of address 1 (after which the timer reloads). `irq_o` and a low `wdt_rst_n` never occur together.
- R6: On expiry with steering 1, `wdt_rst_n` goes to 0 the cycle after the expiring edge and stays 0 for `PULSE_TICKS` ticks. At the edge that ends the pulse, the enable register is cleared (this wins over a write in the same cycle) and the timer reloads.
- R7: A rising or falling edge on `kick_pin` restarts the timer. The pin passes through a two-flop synchronizer, so a change that first meets an edge at edge k takes effect at edge k+2.
- R8: A write to address 0 restarts the timer using the newly written value, and takes priority over a tick in the same cycle.
- R9: A read of address 1 clears the watchdog flag. An expiry in the same cycle leaves the flag set.
- R10: While the reset pulse runs, kicks and control-byte writes do not restart or shorten it. A written byte is still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle 16 Hz timebase pulse |
| kick_pin | input | 1 | Asynchronous kick input, either edge restarts |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flag on address 1) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_o | output | 1 | Level watchdog interrupt, active high |
| wdt_rst_n | output | 1 | Watchdog reset pulse, active low |

## Verification
The assertions assume that `tick` is a single-cycle pulse spaced several clocks apart. They also assume that `rd_en` and `wr_en` are never aimed at the same register in one cycle, and that `kick_pin` is stable through reset. The bench produces a tick every third clock from a free-running divider. It issues each register access as a one-cycle strobe from a task, and changes `kick_pin` only at negative edges after reset is released. A behavioural model that uses integers steps alongside the design and is compared with `rdata`, `irq_o` and `wdt_rst_n` on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned ENA_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ENA  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_IRQ   = 2'd2,
        ST_PULSE = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= pin;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[g] <= 1'b0;
            else        sh_q[g] <= sh_q[g-1];
        end
    end

    assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag_set,
    input  logic              ena_clr,
    output logic [DATA_W-1:0] ctl_q,
    output logic              flag_q,
    output logic [ENA_W-1:0]  ena_q,
    output logic [DATA_W-1:0] rdata
);
    logic ctl_wr, ena_wr, flag_rd;

    assign ctl_wr  = wr_en && (addr == ADDR_CTL);
    assign ena_wr  = wr_en && (addr == ADDR_ENA);
    assign flag_rd = rd_en && (addr == ADDR_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            flag_q <= 1'b0;
            ena_q  <= '0;
        end else begin
            if (ctl_wr) ctl_q <= wdata;
            if (flag_set)     flag_q <= 1'b1;
            else if (flag_rd) flag_q <= 1'b0;
            if (ena_clr)     ena_q <= '0;
            else if (ena_wr) ena_q <= wdata[ENA_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTL:  rdata = ctl_q;
            ADDR_FLAG: rdata[DATA_W-1] = flag_q;
            ADDR_ENA:  rdata[ENA_W-1:0] = ena_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned MULT_W      = 5,
    parameter int unsigned RES_W       = 2,
    parameter int unsigned PULSE_TICKS = 4,
    parameter int unsigned DATA_W      = MULT_W + RES_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [DATA_W-1:0] next_byte,
    input  logic              steer,
    input  logic              flag_rd,
    output logic              flag_set,
    output logic              ena_clr,
    output logic              irq_o,
    output logic              pulse_n
);
    localparam int unsigned MAX_RES_SH = 2 * ((1 << RES_W) - 1);
    localparam int unsigned MAX_LOAD   = ((1 << MULT_W) - 1) << MAX_RES_SH;
    localparam int unsigned CNT_W      = $clog2(MAX_LOAD + 1);
    localparam int unsigned PCNT_W     = $clog2(PULSE_TICKS + 1);

    wdt_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;

    logic [MULT_W-1:0] nmult;
    logic [RES_W-1:0]  nres;
    logic [CNT_W-1:0]  load_val;
    logic              nzero;

    assign nmult    = next_byte[MULT_W+RES_W-1:RES_W];
    assign nres     = next_byte[RES_W-1:0];
    assign nzero    = (nmult == '0);
    assign load_val = CNT_W'(nmult) << {nres, 1'b0};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pcnt_q <= pcnt_d;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        pcnt_d   = pcnt_q;
        flag_set = 1'b0;
        ena_clr  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (restart && !nzero) begin
                    st_d  = ST_COUNT;
                    cnt_d = load_val;
                end
            end
            ST_COUNT: begin
                if (restart) begin
                    if (nzero) st_d = ST_IDLE;
                    else       cnt_d = load_val;
                end else if (tick) begin
                    if (cnt_q == CNT_W'(1)) begin
                        flag_set = 1'b1;
                        if (steer) begin
                            st_d   = ST_PULSE;
                            pcnt_d = PCNT_W'(PULSE_TICKS);
                        end else begin
                            st_d = ST_IRQ;
                        end
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            ST_IRQ: begin
                if (restart || flag_rd) begin
                    if (nzero) begin
                        st_d = ST_IDLE;
                    end else begin
                        st_d  = ST_COUNT;
                        cnt_d = load_val;
                    end
                end
            end
            ST_PULSE: begin
                if (tick) begin
                    if (pcnt_q == PCNT_W'(1)) begin
                        ena_clr = 1'b1;
                        if (nzero) begin
                            st_d = ST_IDLE;
                        end else begin
                            st_d  = ST_COUNT;
                            cnt_d = load_val;
                        end
                    end else begin
                        pcnt_d = pcnt_q - PCNT_W'(1);
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        irq_o   = (st_q == ST_IRQ);
        pulse_n = (st_q != ST_PULSE);
    end

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int unsigned MULT_W      = 5,
    parameter int unsigned RES_W       = 2,
    parameter int unsigned PULSE_TICKS = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = MULT_W + RES_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              kick_pin,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              wdt_rst_n
);
    logic              kick_edge;
    logic              ctl_wr, flag_rd, restart;
    logic              flag_set, ena_clr, flag_q;
    logic [DATA_W-1:0] ctl_q, next_byte;
    logic [ENA_W-1:0]  ena_q;

    assign ctl_wr    = wr_en && (addr == ADDR_CTL);
    assign flag_rd   = rd_en && (addr == ADDR_FLAG);
    assign restart   = kick_edge || ctl_wr;
    assign next_byte = ctl_wr ? wdata : ctl_q;

    wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (kick_pin),
        .edge_o (kick_edge)
    );

    wdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .flag_set (flag_set),
        .ena_clr  (ena_clr),
        .ctl_q    (ctl_q),
        .flag_q   (flag_q),
        .ena_q    (ena_q),
        .rdata    (rdata)
    );

    wdt_fsm #(
        .MULT_W      (MULT_W),
        .RES_W       (RES_W),
        .PULSE_TICKS (PULSE_TICKS),
        .DATA_W      (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (restart),
        .next_byte (next_byte),
        .steer     (ctl_q[DATA_W-1]),
        .flag_rd   (flag_rd),
        .flag_set  (flag_set),
        .ena_clr   (ena_clr),
        .irq_o     (irq_o),
        .pulse_n   (wdt_rst_n)
    );

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk
    import wdt_pkg::*;
#(
    parameter int unsigned MULT_W = 5,
    parameter int unsigned RES_W  = 2,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq_o,
    input logic              wdt_rst_n,
    input logic              kick_edge,
    input logic              flag_set,
    input logic              flag_q,
    input logic [DATA_W-1:0] ctl_q,
    input logic [ENA_W-1:0]  ena_q
);
    logic ctl_wr_c, flag_rd_c;
    assign ctl_wr_c  = wr_en && (addr == ADDR_CTL);
    assign flag_rd_c = rd_en && (addr == ADDR_FLAG);

    // R5
    irq_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && !wdt_rst_n));

    // R4
    mult_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[MULT_W+RES_W-1:RES_W] == '0) |-> !flag_set);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_c && !flag_set) |=> !flag_q);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !kick_edge && !ctl_wr_c && !flag_rd_c) |=> irq_o);

    // R6
    ena_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_n) |-> (ena_q == '0));

    // R10
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst_n && !tick) |=> !wdt_rst_n);

    // R3
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));

endmodule

bind wdt_supervisor wdt_supervisor_chk #(
    .MULT_W (MULT_W),
    .RES_W  (RES_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .irq_o     (irq_o),
    .wdt_rst_n (wdt_rst_n),
    .kick_edge (kick_edge),
    .flag_set  (flag_set),
    .flag_q    (flag_q),
    .ctl_q     (ctl_q),
    .ena_q     (ena_q)
);

// File: tb/wdt_supervisor_bench.sv
module wdt_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 3;
    localparam int PULSE      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       kick_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_o, wdt_rst_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    wdt_supervisor #(.PULSE_TICKS(PULSE)) u_wdt_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick_pin(kick_pin),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .wdt_rst_n(wdt_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // timebase: one tick every TDIV clocks
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TDIV;
        tick = rst_n && (tdiv == 0);
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_st = 0, m_cnt = 0, m_pc = 0, m_ctl = 0, m_ena = 0;
    bit m_flag = 0, k1 = 0, k2 = 0, k3 = 0;

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_ctl;
            1: return m_flag ? 8'h80 : 0;
            2: return m_ena;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_ctl = 0; m_ena = 0;
            m_flag = 0; k1 = 0; k2 = 0; k3 = 0;
        end else begin
            bit kedge, cw, fr, fs, ec, rs;
            int nb, nm, ld;
            kedge = (k2 != k3);
            k3 = k2; k2 = k1; k1 = kick_pin;
            cw = wr_en && addr == 0;
            fr = rd_en && addr == 1;
            rs = kedge || cw;
            nb = cw ? int'(wdata) : m_ctl;
            nm = (nb >> 2) & 31;
            ld = nm * (1 << (2 * (nb & 3)));
            fs = 0; ec = 0;
            case (m_st)
                0: if (rs && nm != 0) begin m_st = 1; m_cnt = ld; end
                1: begin
                    if (rs) begin
                        if (nm == 0) m_st = 0; else m_cnt = ld;
                    end else if (tick) begin
                        if (m_cnt == 1) begin
                            fs = 1;
                            if ((m_ctl & 8'h80) != 0) begin m_st = 3; m_pc = PULSE; end
                            else m_st = 2;
                        end else m_cnt--;
                    end
                end
                2: if (rs || fr) begin
                    if (nm == 0) m_st = 0; else begin m_st = 1; m_cnt = ld; end
                end
                default: if (tick) begin
                    if (m_pc == 1) begin
                        ec = 1;
                        if (nm == 0) m_st = 0; else begin m_st = 1; m_cnt = ld; end
                    end else m_pc--;
                end
            endcase
            if (cw) m_ctl = wdata;
            if (ec) m_ena = 0;
            else if (wr_en && addr == 2) m_ena = wdata & 15;
            if (fs) m_flag = 1;
            else if (fr) m_flag = 0;
        end
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            check("R5 irq_o vs model", irq_o, m_st == 2);
            check("R6 wdt_rst_n vs model", wdt_rst_n, m_st != 3);
            check("R2 rdata vs model", rdata, exp_rdata(addr));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; addr = 2'(a); wdata = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input int a, input string tag, input int exp);
        @(negedge clk); addr = 2'(a); #1;
        check(tag, rdata, exp);
    endtask

    task automatic rd_flag(input string tag, input int exp);
        @(negedge clk); addr = 2'd1; rd_en = 1; #1;
        check(tag, rdata, exp);
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_irq(input int lim, output bit seen);
        seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk); #1;
            if (irq_o) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        int lowc;
        repeat (3) @(negedge clk);
        #1;
        check("R1 irq_o at reset", irq_o, 0);
        check("R1 wdt_rst_n at reset", wdt_rst_n, 1);
        @(negedge clk); rst_n = 1;
        peek(0, "R1 control byte after reset", 0);
        peek(1, "R1 flag after reset", 0);
        peek(2, "R1 enable after reset", 0);

        // steering 0, mult 3, res 00 -> 3 ticks
        wr(0, 8'h0C);
        peek(0, "R2 control byte readback", 8'h0C);
        #1; check("R3 no early expiry", irq_o, 0);
        wait_irq(40, seen);
        check("R5 interrupt on expiry", seen, 1);
        repeat (5) @(negedge clk);
        #1; check("R5 interrupt held", irq_o, 1);
        rd_flag("R9 flag set on read", 8'h80);
        #1; check("R5 interrupt dropped after flag read", irq_o, 0);
        peek(1, "R9 flag cleared by read", 0);

        // kicks keep it alive: mult 2, res 01 -> 8 ticks
        wr(0, 8'h09);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            repeat (10) @(negedge clk);
            kick_pin = ~kick_pin;
            #1; if (irq_o) seen = 1;
        end
        check("R7 kicks on both edges prevent expiry", seen, 0);
        wait_irq(80, seen);
        check("R7 expiry once kicks stop", seen, 1);
        rd_flag("R9 flag read after kick test", 8'h80);

        // control writes keep it alive
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            wr(0, 8'h09);
            repeat (13) @(negedge clk);
            #1; if (irq_o) seen = 1;
        end
        check("R8 control writes prevent expiry", seen, 0);

        // multiplier 0 disables
        wr(0, 8'h03);
        rd_flag("R9 flag clear before idle", 0);
        wait_irq(300, seen);
        check("R4 no interrupt with multiplier 0", seen, 0);
        peek(1, "R4 no flag with multiplier 0", 0);
        #1; check("R4 no reset pulse", wdt_rst_n, 1);

        // steering 1, mult 1, res 00
        wr(2, 8'hFF);
        peek(2, "R2 enable readback masked", 8'h0F);
        wr(0, 8'h84);
        lowc = 0;
        for (int i = 0; i < 40 && wdt_rst_n; i++) @(negedge clk);
        #1; check("R6 reset pulse asserted", wdt_rst_n, 0);
        kick_pin = ~kick_pin;
        wr(0, 8'h84);
        while (!wdt_rst_n && lowc < 100) begin @(negedge clk); lowc++; end
        check("R10 pulse not shortened by kick or write", lowc >= (PULSE - 1) * TDIV - 3, 1);
        peek(2, "R6 enables cleared at pulse end", 0);
        wr(0, 8'h00);
        rd_flag("R6 flag set by reset expiry", 8'h80);

        // long resolution: mult 1, res 11 -> 64 ticks
        wr(0, 8'h07);
        wait_irq(150, seen);
        check("R3 64-tick step not early", seen, 0);
        wait_irq(120, seen);
        check("R3 64-tick step expires", seen, 1);
        rd_flag("R9 final flag read", 8'h80);
        wr(0, 8'h00);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule